// File: doc/BRIEF.md
# Dual-Bank Alternating Storage for a 32-Point Complex FFT

This block holds the working data of a 32-point radix-2 transform. It contains two banks. Each bank keeps 32 complex words, with a real and an imaginary half of `DW` bits each, and each bank has two ports. During a butterfly level one bank is the read bank. Port A of the read bank supplies operand G and port B supplies operand H. The other bank is the write bank. Its port A stores result X and its port B stores result Y.

The banks swap roles at the end of each burst of result writes. A delayed copy of the write strobe detects the falling edge, and a toggle flop then flips the read-bank select. An asynchronous clear sets the select to bank 0, so the first level reads bank 0 and writes bank 1.

In load mode a new sample is written into the current read bank at the bit-reversed value of the load address. In the same cycle, the word held at the unreversed load address comes out on H, so results can be read out while the next frame loads. All address, data and strobe inputs pass through one registered multiplexer stage. The RAM adds two cycles of read latency and the output selector adds one more.

Top module: `fft_pingpong_mem`

## Requirements
- R1: While `rst_n` is low, `rd_bank` is 0, and it is still 0 on the first cycle after reset is released.
- R2: With `load` high, `{ld_re, ld_im}` is stored in the read bank at address `bitrev(ld_addr)`. For example, load address 1 lands at address 16 and load address 3 at address 24. A later compute read at that address returns the stored sample.
- R3: With `load` high, `{h_re, h_im}` shows the read-bank word at the unreversed `ld_addr`, four cycles after the inputs are presented.
- R4: With `load` low, `{g_re, g_im}` shows the read-bank word at `rd_addr_a` and `{h_re, h_im}` shows the word at `rd_addr_b`, exactly four clock cycles after the addresses are presented.
- R5: With `load` low and `mem_wr` high, X is written at `wr_addr_a` and Y at `wr_addr_b` in the bank that is not selected by `rd_bank`. The read bank is left untouched. With `mem_wr` low, neither bank is written.
- R6: `rd_bank` inverts exactly once after a cycle in which `load` is low, `mem_wr` is low and `mem_wr` was high in the previous cycle. It holds its value in every other cycle, including when `mem_wr` pulses while `load` is high.
- R7: When a load-mode write and the H readout hit the same address in the same cycle (an address equal to its own bit reversal, such as 0, 4 or 10), H returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| load | input | 1 | 1 = load/readout mode, 0 = compute mode |
| ld_addr | input | AW | Natural-order load/readout address |
| ld_re | input | DW | Real part of the incoming sample |
| ld_im | input | DW | Imaginary part of the incoming sample |
| mem_wr | input | 1 | Result write strobe, held high through each burst |
| rd_addr_a | input | AW | Read address for operand G |
| rd_addr_b | input | AW | Read address for operand H |
| wr_addr_a | input | AW | Write address for result X |
| wr_addr_b | input | AW | Write address for result Y |
| x_re | input | DW | Result X, real |
| x_im | input | DW | Result X, imaginary |
| y_re | input | DW | Result Y, real |
| y_im | input | DW | Result Y, imaginary |
| g_re | output | DW | Operand G, real |
| g_im | output | DW | Operand G, imaginary |
| h_re | output | DW | Operand H or readout word, real |
| h_im | output | DW | Operand H or readout word, imaginary |
| rd_bank | output | 1 | Current read bank (0 or 1) |

## Verification
The bench builds the block with its default parameters: `AW = 5`, for 32 words, and `DW = 16`. With these values every address of both banks is reachable and is swept in every pass. Five write bursts give an odd number of bank swaps, and the small address space contains several bit-reversal palindromes (0, 4, 10, 14, 17, 21, 27, 31), where the load write and the readout collide. A bench model of both banks predicts each G and H value at the fourth cycle. The same model tracks the bank select through write bursts, through a strobe pulse inside load mode, and through a clear applied in the middle of the run.

// File: rtl/fft_pingpong_mem.sv
module fft_pingpong_mem #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_re,
  input  logic [DW-1:0] ld_im,
  input  logic          mem_wr,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [AW-1:0] wr_addr_a,
  input  logic [AW-1:0] wr_addr_b,
  input  logic [DW-1:0] x_re,
  input  logic [DW-1:0] x_im,
  input  logic [DW-1:0] y_re,
  input  logic [DW-1:0] y_im,
  output logic [DW-1:0] g_re,
  output logic [DW-1:0] g_im,
  output logic [DW-1:0] h_re,
  output logic [DW-1:0] h_im,
  output logic          rd_bank
);
  localparam int DEPTH = 1 << AW;
  localparam int NB    = 2;

  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] v);
    for (int i = 0; i < AW; i++) bitrev[i] = v[AW-1-i];
  endfunction

  logic wr_dly, sel;
  wire  burst_end = wr_dly & ~mem_wr & ~load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_dly <= 1'b0;
      sel    <= 1'b0;
    end else begin
      wr_dly <= mem_wr;
      if (burst_end) sel <= ~sel;
    end

  assign rd_bank = sel;

  logic [2:0] sel_pipe;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_pipe <= '0;
    else        sel_pipe <= {sel_pipe[1:0], sel};

  logic [DW-1:0] pa_re [NB];
  logic [DW-1:0] pa_im [NB];
  logic [DW-1:0] pb_re [NB];
  logic [DW-1:0] pb_im [NB];
  logic [NB-1:0] we_any;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    wire is_rd = (sel == b[0]);

    logic [AW-1:0] a_addr, b_addr;
    logic          a_we, b_we;
    logic [DW-1:0] a_wre, a_wim, b_wre, b_wim;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        a_addr <= '0; b_addr <= '0;
        a_we   <= 1'b0; b_we <= 1'b0;
        a_wre  <= '0; a_wim <= '0;
        b_wre  <= '0; b_wim <= '0;
      end else if (load) begin
        a_addr <= bitrev(ld_addr);
        a_we   <= is_rd;
        a_wre  <= ld_re;
        a_wim  <= ld_im;
        b_addr <= ld_addr;
        b_we   <= 1'b0;
        b_wre  <= '0;
        b_wim  <= '0;
      end else if (is_rd) begin
        a_addr <= rd_addr_a;
        b_addr <= rd_addr_b;
        a_we   <= 1'b0;
        b_we   <= 1'b0;
        a_wre  <= '0; a_wim <= '0;
        b_wre  <= '0; b_wim <= '0;
      end else begin
        a_addr <= wr_addr_a;
        b_addr <= wr_addr_b;
        a_we   <= mem_wr;
        b_we   <= mem_wr;
        a_wre  <= x_re; a_wim <= x_im;
        b_wre  <= y_re; b_wim <= y_im;
      end

    assign we_any[b] = a_we | b_we;

    logic [DW-1:0] m_re [DEPTH];
    logic [DW-1:0] m_im [DEPTH];
    logic [DW-1:0] a1_re, a1_im, b1_re, b1_im;
    logic [DW-1:0] a2_re, a2_im, b2_re, b2_im;

    always_ff @(posedge clk) begin
      if (a_we) begin
        m_re[a_addr] <= a_wre;
        m_im[a_addr] <= a_wim;
      end
      if (b_we) begin
        m_re[b_addr] <= b_wre;
        m_im[b_addr] <= b_wim;
      end
      a1_re <= m_re[a_addr];
      a1_im <= m_im[a_addr];
      b1_re <= m_re[b_addr];
      b1_im <= m_im[b_addr];
      a2_re <= a1_re;
      a2_im <= a1_im;
      b2_re <= b1_re;
      b2_im <= b1_im;
    end

    assign pa_re[b] = a2_re;
    assign pa_im[b] = a2_im;
    assign pb_re[b] = b2_re;
    assign pb_im[b] = b2_im;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      g_re <= '0; g_im <= '0;
      h_re <= '0; h_im <= '0;
    end else begin
      g_re <= pa_re[sel_pipe[2]];
      g_im <= pa_im[sel_pipe[2]];
      h_re <= pb_re[sel_pipe[2]];
      h_im <= pb_im[sel_pipe[2]];
    end
endmodule

module fft_pingpong_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       mem_wr,
  input logic       rd_bank,
  input logic [1:0] we_any
);
  a_r1_clear_bank0: assert property (@(posedge clk) !rst_n |-> !rd_bank);

  a_r6_swap_on_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $fell(mem_wr)) |=> (rd_bank != $past(rd_bank)));

  a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(!load && $fell(mem_wr)) |=> $stable(rd_bank));

  a_r5_write_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mem_wr && !rd_bank) |=> (we_any == 2'b10));

  a_r5_write_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mem_wr && rd_bank) |=> (we_any == 2'b01));

  a_r5_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !mem_wr) |=> (we_any == 2'b00));

  a_r2_load_into_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !rd_bank) |=> (we_any == 2'b01));

  a_r2_load_into_bank1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rd_bank) |=> (we_any == 2'b10));
endmodule

bind fft_pingpong_mem fft_pingpong_mem_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .mem_wr (mem_wr),
  .rd_bank(rd_bank),
  .we_any (we_any)
);

// File: tb/fft_pingpong_mem_tb.sv
`timescale 1ns/1ps
module fft_pingpong_mem_tb;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          load, mem_wr;
  logic [AW-1:0] ld_addr, rd_addr_a, rd_addr_b, wr_addr_a, wr_addr_b;
  logic [DW-1:0] ld_re, ld_im, x_re, x_im, y_re, y_im;
  logic [DW-1:0] g_re, g_im, h_re, h_im;
  logic          rd_bank;

  fft_pingpong_mem #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr),
    .ld_re(ld_re), .ld_im(ld_im), .mem_wr(mem_wr),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .g_re(g_re), .g_im(g_im), .h_re(h_re), .h_im(h_im),
    .rd_bank(rd_bank)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // staged stimulus, applied at the next negedge by step()
  bit            s_ld, s_wr;
  logic [AW-1:0] s_la, s_ra, s_rb, s_wa, s_wb;
  logic [DW-1:0] s_lre, s_lim, s_xr, s_xi, s_yr, s_yi;

  logic [2*DW-1:0] mm [2][N];
  bit              mv [2][N];
  bit              m_sel, m_prev;

  bit              p_v  [4];
  bit              p_cg [4];
  bit              p_ch [4];
  logic [2*DW-1:0] p_g  [4];
  logic [2*DW-1:0] p_h  [4];
  string           p_tag[4];

  function automatic logic [AW-1:0] brev(input logic [AW-1:0] v);
    for (int i = 0; i < AW; i++) brev[i] = v[AW-1-i];
  endfunction

  function automatic logic [AW-1:0] rotl(input logic [AW-1:0] v, input int s);
    logic [AW-1:0] r = v;
    for (int i = 0; i < s; i++) r = {r[AW-2:0], r[AW-1]};
    return r;
  endfunction

  task automatic check(input string tag, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_stage();
    s_ld = 0; s_wr = 0; s_la = '0; s_lre = '0; s_lim = '0;
    s_ra = '0; s_rb = '0; s_wa = '0; s_wb = '0;
    s_xr = '0; s_xi = '0; s_yr = '0; s_yi = '0;
  endtask

  task automatic flush_pipe();
    for (int i = 0; i < 4; i++) begin
      p_v[i] = 0; p_cg[i] = 0; p_ch[i] = 0;
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    if (p_v[3]) begin
      if (p_cg[3]) check({p_tag[3], " G"}, {g_re, g_im}, p_g[3]);
      if (p_ch[3]) check({p_tag[3], " H"}, {h_re, h_im}, p_h[3]);
    end
    check("R6 bank select", {{(2*DW-1){1'b0}}, rd_bank}, {{(2*DW-1){1'b0}}, m_sel});
    for (int i = 3; i > 0; i--) begin
      p_v[i] = p_v[i-1]; p_cg[i] = p_cg[i-1]; p_ch[i] = p_ch[i-1];
      p_g[i] = p_g[i-1]; p_h[i] = p_h[i-1]; p_tag[i] = p_tag[i-1];
    end
    load = s_ld; mem_wr = s_wr; ld_addr = s_la; ld_re = s_lre; ld_im = s_lim;
    rd_addr_a = s_ra; rd_addr_b = s_rb; wr_addr_a = s_wa; wr_addr_b = s_wb;
    x_re = s_xr; x_im = s_xi; y_re = s_yr; y_im = s_yi;
    p_v[0] = 1;
    if (s_ld) begin
      p_cg[0] = 0;
      p_ch[0] = mv[m_sel][s_la];
      p_h[0]  = mm[m_sel][s_la];
      p_tag[0] = (brev(s_la) == s_la) ? "R7" : "R3";
      mm[m_sel][brev(s_la)] = {s_lre, s_lim};
      mv[m_sel][brev(s_la)] = 1;
    end else begin
      p_cg[0] = mv[m_sel][s_ra];
      p_ch[0] = mv[m_sel][s_rb];
      p_g[0]  = mm[m_sel][s_ra];
      p_h[0]  = mm[m_sel][s_rb];
      p_tag[0] = tag;
      if (s_wr) begin
        mm[!m_sel][s_wa] = {s_xr, s_xi}; mv[!m_sel][s_wa] = 1;
        mm[!m_sel][s_wb] = {s_yr, s_yi}; mv[!m_sel][s_wb] = 1;
      end
      if (m_prev && !s_wr) m_sel = !m_sel;
    end
    m_prev = s_wr;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_stage();
    load = 0; mem_wr = 0;
    repeat (2) @(negedge clk);
    check("R1 bank during clear", {{(2*DW-1){1'b0}}, rd_bank}, '0);
    rst_n = 1;
    m_sel = 0; m_prev = 0;
    flush_pipe();
    @(negedge clk);
    check("R1 bank after clear", {{(2*DW-1){1'b0}}, rd_bank}, '0);
  endtask

  task automatic load_pass(input bit pulse);
    for (int i = 0; i < N; i++) begin
      s_ld = 1; s_la = i[AW-1:0];
      s_lre = DW'($urandom); s_lim = DW'($urandom);
      s_wr = pulse && (i == 10);
      step("R3");
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F7F));
    for (int b = 0; b < 2; b++) for (int a = 0; a < N; a++) mv[b][a] = 0;
    idle_stage();
    load = 0; mem_wr = 0; ld_addr = '0; ld_re = '0; ld_im = '0;
    rd_addr_a = '0; rd_addr_b = '0; wr_addr_a = '0; wr_addr_b = '0;
    x_re = '0; x_im = '0; y_re = '0; y_im = '0;
    rst_n = 0;
    flush_pipe();
    do_reset();

    // R2/R3/R6: first frame load, with a strobe pulse inside load mode
    load_pass(1'b1);

    // five compute levels; first level reads the loaded frame (R2)
    for (int lvl = 0; lvl < AW; lvl++) begin
      for (int j = 0; j < N/2; j++) begin
        idle_stage();
        s_wr = 1;
        s_ra = AW'($urandom); s_rb = AW'($urandom);
        if (j == 0) begin s_ra = '0; s_rb = brev(AW'(1)); end
        s_wa = rotl({j[AW-2:0], 1'b0}, lvl);
        s_wb = rotl({j[AW-2:0], 1'b1}, lvl);
        s_xr = DW'($urandom); s_xi = DW'($urandom);
        s_yr = DW'($urandom); s_yi = DW'($urandom);
        step(lvl == 0 ? "R2" : "R5");
      end
      idle_stage();
      s_ra = AW'($urandom); s_rb = AW'($urandom);
      step(lvl == 0 ? "R2" : "R5");
    end

    // read-only compute pass with full address sweep (R4)
    for (int i = 0; i < N; i++) begin
      idle_stage();
      s_ra = i[AW-1:0]; s_rb = AW'(N - 1 - i);
      step("R4");
    end

    // readout of results while the next frame loads (R3, R7 on palindromes)
    load_pass(1'b0);

    // drain pipeline with reads of the new frame (R2)
    for (int i = 0; i < 8; i++) begin
      idle_stage();
      s_ra = brev(AW'(i)); s_rb = AW'($urandom);
      step("R2");
    end

    // clear in mid-run returns the select to bank 0
    do_reset();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule